// File: doc/BRIEF.md
# Three-Wire Clock Serial Access Port

This block is the slave side of a three-wire serial link to a real-time clock. The three wires are a chip-enable level, a serial clock and one data line that carries data in both directions. The line is exposed as separate input, output and output-enable signals. All serial inputs are sampled in the system clock domain, and serial clock edges are detected there.

While chip-enable is high, the level on the data line at the first serial rising edge sets the direction of the frame. A frame is eight preamble edges followed by a 52-bit word, sent least significant bit first. The word holds, in ascending byte order:

- seconds
- minutes
- hours
- weekday
- day
- month
- a status nibble

For reads, the port takes a snapshot of the counter values and streams it out. For writes, it collects the word and hands it to the counters with a one-cycle load strobe, but only after a complete frame. While a write is in progress, the port holds off the one-second increment and clears the sub-second divider. It also keeps three state bits of its own:

- an output-frequency select bit
- a test bit
- a sticky low-supply flag, which is cleared by a long enough read

Top module: `rtc3w_port`

## Requirements
- R1: With chip-enable high, data low at the first serial rising edge makes the frame a read; data high makes it a write. A read frame never produces a load strobe.
- R2: In a read, the word is captured on the 8th serial falling edge. Bits 47:0 come from `time_in`, except that bit 27 carries the frequency-select bit and bit 28 carries the test bit. Bit 48 carries the low-supply flag and bits 51:49 are zero. A change on `time_in` after the capture does not alter the streamed data.
- R3: From the 9th to the 60th serial rising edge, each rising edge puts the next word bit on `dio_out`, starting at bit 0. After the 60th edge, `dio_out` holds bit 51 however many more edges arrive.
- R4: `dio_oe` is high only during a read frame, from the 9th rising edge on, and only while chip-enable is high.
- R5: A write of exactly 60 rising edges produces one single-cycle `time_load` pulse, with `time_out` equal to bits 47:0 of the word written.
- R6: A write in which chip-enable drops before the 60th rising edge produces no load. Edges after the 60th leave the loaded value unchanged.
- R7: In a write, `tick_hold` is high from the first serial falling edge until chip-enable drops. `div_clr` is high from the first falling edge until the second rising edge.
- R8: The test bit takes word bit 28 at a complete write and is cleared while chip-enable is low.
- R9: The frequency select `fsel` resets to 0, takes word bit 27 at a complete write, and changes at no other time.
- R10: A high `lowv_in` sets the low-supply flag. The flag is cleared when chip-enable falls at the end of a read of at least 56 rising edges. A read of 55 edges or fewer leaves it set, and a set request in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ce | input | 1 | Serial chip-enable |
| sclk | input | 1 | Serial clock |
| dio_in | input | 1 | Data line input |
| dio_out | output | 1 | Data line output value |
| dio_oe | output | 1 | Data line output enable |
| time_in | input | 48 | Current counter values |
| time_out | output | 48 | Value to load into the counters |
| time_load | output | 1 | One-cycle load strobe |
| lowv_in | input | 1 | Low-supply indication |
| lowv_flag | output | 1 | Sticky low-supply flag |
| fsel | output | 1 | Frequency-out select (0: 1 Hz, 1: 32.768 kHz) |
| test_mode | output | 1 | Test bit |
| tick_hold | output | 1 | Inhibit the one-second increment |
| div_clr | output | 1 | Clear the sub-second divider |

## Verification
The flag clear at the end of a long read can fall in the same cycle as a new low-supply indication. The bench provokes this by holding `lowv_in` high through the falling edge of chip-enable after a full 60-edge read. It expects the flag to stay set. It also places a change of `time_in` just after the 8th falling edge, so that a one-second carry collides with a snapshot already taken. It then judges every streamed bit against the value from before the change.

// File: rtl/rtc3w_port.sv
module rtc3w_port #(
  parameter int PRE_W    = 8,
  parameter int FIELD_W  = 52,
  parameter int TIME_W   = 48,
  parameter int CLR_LEN  = 56,
  parameter int FSEL_BIT = 27,
  parameter int TEST_BIT = 28,
  parameter int FLAG_BIT = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              sclk,
  input  logic              dio_in,
  output logic              dio_out,
  output logic              dio_oe,
  input  logic [TIME_W-1:0] time_in,
  output logic [TIME_W-1:0] time_out,
  output logic              time_load,
  input  logic              lowv_in,
  output logic              lowv_flag,
  output logic              fsel,
  output logic              test_mode,
  output logic              tick_hold,
  output logic              div_clr
);
  localparam int FRAME = PRE_W + FIELD_W;
  localparam int CW = $clog2(FRAME + 1);
  localparam logic [CW-1:0] FRAME_C = CW'(FRAME);
  localparam logic [CW-1:0] LAST_C  = CW'(FRAME - 1);
  localparam logic [CW-1:0] PRE_C   = CW'(PRE_W);
  localparam logic [CW-1:0] CLR_C   = CW'(CLR_LEN);
  localparam logic [CW-1:0] TWO_C   = CW'(2);

  typedef enum logic [1:0] {M_IDLE, M_RD, M_WR} mode_t;

  mode_t              mode;
  logic [CW-1:0]      cnt;
  logic [FIELD_W-1:0] sh, snap, shin;
  logic               sclk_q, ce_q, dout, fell1, load_q, fsel_q, test_q, flag_q;

  wire rise = ce & sclk & ~sclk_q;
  wire fall = ce & ~sclk & sclk_q;
  assign shin = {dio_in, sh[FIELD_W-1:1]};

  always_comb begin
    snap = '0;
    snap[TIME_W-1:0] = time_in;
    snap[FSEL_BIT] = fsel_q;
    snap[TEST_BIT] = test_q;
    snap[FLAG_BIT] = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_IDLE; cnt <= '0; sh <= '0; sclk_q <= 1'b0; ce_q <= 1'b0;
      dout <= 1'b0; fell1 <= 1'b0; load_q <= 1'b0; fsel_q <= 1'b0; test_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      ce_q   <= ce;
      load_q <= 1'b0;
      if (!ce) begin
        mode <= M_IDLE; cnt <= '0; fell1 <= 1'b0; test_q <= 1'b0;
      end else begin
        if (rise) begin
          if (cnt != FRAME_C) cnt <= cnt + 1'b1;
          if (mode == M_IDLE) mode <= dio_in ? M_WR : M_RD;
          else if (cnt >= PRE_C && cnt < FRAME_C) begin
            if (mode == M_RD) begin
              dout <= sh[0];
              sh   <= sh >> 1;
            end else begin
              sh <= shin;
              if (cnt == LAST_C) begin
                load_q <= 1'b1;
                fsel_q <= shin[FSEL_BIT];
                test_q <= shin[TEST_BIT];
              end
            end
          end
        end
        if (fall) begin
          if (mode == M_WR) fell1 <= 1'b1;
          if (mode == M_RD && cnt == PRE_C) sh <= snap;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (lowv_in) flag_q <= 1'b1;
    else if (ce_q && !ce && mode == M_RD && cnt >= CLR_C) flag_q <= 1'b0;
  end

  assign dio_out   = dout;
  assign dio_oe    = ce && mode == M_RD && cnt > PRE_C;
  assign time_out  = sh[TIME_W-1:0];
  assign time_load = load_q;
  assign lowv_flag = flag_q;
  assign fsel      = fsel_q;
  assign test_mode = test_q;
  assign tick_hold = ce && mode == M_WR && fell1;
  assign div_clr   = tick_hold && cnt < TWO_C;
endmodule

// File: rtl/rtc3w_port_chk.sv
module rtc3w_port_chk (
  input logic clk,
  input logic rst_n,
  input logic ce,
  input logic dio_oe,
  input logic time_load,
  input logic test_mode,
  input logic lowv_in,
  input logic lowv_flag,
  input logic fsel
);
  // R4
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) dio_oe |-> ce);
  // R5
  load_single_chk: assert property (@(posedge clk) disable iff (!rst_n) time_load |=> !time_load);
  // R8
  test_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) !ce |=> !test_mode);
  // R10
  lowv_set_chk: assert property (@(posedge clk) disable iff (!rst_n) lowv_in |=> lowv_flag);
  // R9
  fsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(fsel) |-> time_load);
endmodule

bind rtc3w_port rtc3w_port_chk u_chk (.*);

// File: tb/rtc3w_port_tb.sv
module rtc3w_port_tb;
  logic clk = 0, rst_n = 0, ce = 0, sclk = 0, dio_in = 0, lowv_in = 0;
  logic [47:0] time_in = 48'h12_31_05_23_59_50;
  logic [47:0] time_out, last_load;
  logic dio_out, dio_oe, time_load, lowv_flag, fsel, test_mode, tick_hold, div_clr;
  int checks = 0, fails = 0, loads = 0;

  always #2.5 clk = ~clk;

  rtc3w_port u_dut (.*);

  always @(negedge clk) if (time_load) begin loads++; last_load = time_out; end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic rise(input logic b);
    dio_in = b; sclk = 1; repeat (3) @(negedge clk);
  endtask
  task automatic fall();
    sclk = 0; repeat (3) @(negedge clk);
  endtask
  task automatic end_frame();
    ce = 0; dio_in = 0; repeat (4) @(negedge clk);
  endtask

  function automatic logic [51:0] snapw(input logic [47:0] t);
    logic [51:0] s;
    s = {4'b0, t};
    s[27] = fsel; s[28] = test_mode; s[48] = lowv_flag;
    return s;
  endfunction

  task automatic wr_frame(input logic [51:0] w, input int n);
    ce = 1; repeat (2) @(negedge clk);
    for (int e = 1; e <= n; e++) begin
      rise(e == 1 ? 1'b1 : e <= 8 ? 1'b0 : e <= 60 ? w[e-9] : 1'b1);
      if (e == 1) chk(!tick_hold, "R7 hold before first fall", tick_hold, 0);
      if (e == 2) chk(!div_clr, "R7 div_clr after second rise", div_clr, 0);
      fall();
      if (e == 1) chk(tick_hold && div_clr, "R7 hold/clr after first fall", {tick_hold, div_clr}, 2'b11);
    end
  endtask

  task automatic rd_frame(input int n, input bit bump, input logic [51:0] exp);
    int bad = 0;
    ce = 1; repeat (2) @(negedge clk);
    for (int e = 1; e <= n; e++) begin
      rise(1'b0);
      if (e == 8) chk(!dio_oe, "R4 oe off in preamble", dio_oe, 0);
      if (e >= 9 && e <= 60 && (dio_out !== exp[e-9] || !dio_oe)) bad++;
      if (e > 60) chk(dio_out === exp[51] && dio_oe, "R3 hold after 60", dio_out, exp[51]);
      fall();
      if (e == 8 && bump) time_in = time_in + 1;
    end
    if (n >= 60) chk(bad == 0, "R2/R3 streamed bits", bad, 0);
  endtask

  task automatic t_reset();
    chk(fsel == 0, "R9 reset fsel", fsel, 0);
    chk(dio_oe == 0, "R4 reset oe", dio_oe, 0);
    chk(lowv_flag == 0, "R10 reset flag", lowv_flag, 0);
    chk(test_mode == 0 && time_load == 0, "R8 reset test", test_mode, 0);
  endtask

  task automatic t_write_full();
    logic [51:0] w = 52'hF_07_15_1B_09_42_33;
    wr_frame(w, 60);
    @(negedge clk);
    chk(loads == 1, "R5 one load", loads, 1);
    chk(last_load == w[47:0], "R5 load value", last_load, w[47:0]);
    chk(fsel == 1, "R9 fsel from bit27", fsel, 1);
    chk(test_mode == 1, "R8 test from bit28", test_mode, 1);
    chk(tick_hold == 1, "R7 hold until ce low", tick_hold, 1);
    end_frame();
    chk(test_mode == 0, "R8 test cleared by ce low", test_mode, 0);
    chk(tick_hold == 0, "R7 hold released", tick_hold, 0);
  endtask

  task automatic t_write_short();
    wr_frame(52'h0_00_00_00_00_00_00, 50);
    end_frame();
    chk(loads == 1, "R6 short write discarded", loads, 1);
    chk(fsel == 1, "R9 fsel kept on short write", fsel, 1);
  endtask

  task automatic t_write_long();
    logic [51:0] w = 52'h0_11_22_0A_13_24_35;
    wr_frame(w, 70);
    end_frame();
    chk(loads == 2, "R6 long write one load", loads, 2);
    chk(last_load == w[47:0], "R6 extra bits ignored", last_load, w[47:0]);
    chk(fsel == 1, "R9 fsel bit27 set", fsel, 1);
  endtask

  task automatic t_read();
    logic [51:0] exp = snapw(time_in);
    rd_frame(64, 1, exp);
    end_frame();
    chk(dio_oe == 0, "R4 oe off after ce low", dio_oe, 0);
    chk(loads == 2, "R1 read made no load", loads, 2);
  endtask

  task automatic t_lowv();
    @(negedge clk) lowv_in = 1; @(negedge clk) lowv_in = 0; @(negedge clk);
    chk(lowv_flag == 1, "R10 flag set", lowv_flag, 1);
    rd_frame(55, 0, '0); end_frame();
    chk(lowv_flag == 1, "R10 55-edge read keeps flag", lowv_flag, 1);
    rd_frame(56, 0, '0); end_frame();
    chk(lowv_flag == 0, "R10 56-edge read clears flag", lowv_flag, 0);
    lowv_in = 1; @(negedge clk);
    rd_frame(60, 0, snapw(time_in)); end_frame();
    lowv_in = 0; @(negedge clk);
    chk(lowv_flag == 1, "R10 set wins over clear", lowv_flag, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk); rst_n = 1; repeat (2) @(negedge clk);
    t_reset();
    t_write_full();
    t_write_short();
    t_write_long();
    t_read();
    t_lowv();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule